// File: doc/BRIEF.md
# Subranging Converter Code Correction

This block is the digital back end of a two-stage subranging converter that produces a 6-bit result. The first stage resolves a 3-bit coarse code. The second stage resolves a 4-bit fine code from the amplified residue. The fine stage carries one spare bit above the three bits it contributes. That spare bit lets a residue that has strayed above the nominal range of the second stage be folded back into the coarse code.

The two stages work on a sample one after the other. The coarse code for a sample therefore arrives `ALIGN_LAT` clocks before the matching fine code. The block holds each coarse code in a short delay line until its fine partner arrives. It then forms the corrected word and registers it with a valid strobe. Throughput is one sample per clock.

The correction rule depends on the top bit of the fine code:
- When that bit is clear, the coarse code passes through unchanged.
- When that bit is set, the coarse code is incremented by one.
- When the increment would carry out of the coarse width, the result is clamped to full scale and an overrange flag is raised.

Top module: `adc_subrange_corr`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `out_vld`, `out_word` and `out_ovr` are all 0.
- R2: `out_vld` is 1 in the clock cycle right after a cycle with `fin_vld` = 1. It is 0 after every cycle with `fin_vld` = 0.
- R3: When no clamp occurs, `out_word[2:0]` equals `fin_code[2:0]` of the fine code that was accepted.
- R4: When `fin_code[3]` = 0, `out_word[5:3]` equals the coarse code of the same sample, and `out_ovr` = 0.
- R5: When `fin_code[3]` = 1 and the coarse code is below 7, `out_word[5:3]` equals the coarse code plus one, and `out_ovr` = 0.
- R6: When `fin_code[3]` = 1 and the coarse code is 7, `out_word` = 63 and `out_ovr` = 1, whatever the value of `fin_code[2:0]`. `out_ovr` is 1 only in this case.
- R7: A coarse code accepted with `crs_vld` = 1 in cycle t pairs with the fine code accepted with `fin_vld` = 1 in cycle t + `ALIGN_LAT` (default 1). New samples may start on every clock.
- R8: In a cycle after one with `fin_vld` = 0, `out_word` and `out_ovr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| crs_vld | input | 1 | Coarse code present this cycle |
| crs_code | input | 3 | Coarse code from the first stage |
| fin_vld | input | 1 | Fine code present this cycle |
| fin_code | input | 4 | Fine code from the second stage; bit 3 is the redundancy bit |
| out_vld | output | 1 | Corrected word valid |
| out_word | output | 6 | Corrected result |
| out_ovr | output | 1 | Result was clamped at full scale |

## Verification
A coarse code driven at one falling edge is captured by the delay line on the next rising edge. Its fine partner is driven one clock later, and the corrected result is visible after the rising edge that follows that fine code. The bench drives inputs on falling edges and samples outputs on the next falling edge after the fine code's rising edge, which is exactly one clock after the fine code was presented. One falling edge later it checks that the valid strobe has dropped and that the word and flag have held. A back-to-back stream checks each result on the falling edge two clocks after its coarse code was driven, while later samples are already entering the pipeline.

// File: rtl/adc_subrange_pkg.sv
package adc_subrange_pkg;

    // Action chosen by the correction stage for one sample
    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,   // redundancy bit clear: coarse unchanged
        ACT_INCR = 2'd1,   // redundancy bit set: coarse + 1
        ACT_SAT  = 2'd2    // increment would carry out: clamp
    } corr_act_e;

    localparam int unsigned CRS_W_DEF     = 3;
    localparam int unsigned FIN_W_DEF     = 4;
    localparam int unsigned ALIGN_LAT_DEF = 1;

endpackage

// File: rtl/adc_sr_crs_delay.sv
module adc_sr_crs_delay #(
    parameter int unsigned W     = 3,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_code,
    output logic         out_vld,
    output logic [W-1:0] out_code
);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     code_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    code_q[g] <= '0;
                end else begin
                    vld_q[g]  <= in_vld;
                    code_q[g] <= in_vld ? in_code : '0;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    code_q[g] <= '0;
                end else begin
                    vld_q[g]  <= vld_q[g-1];
                    code_q[g] <= code_q[g-1];
                end
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_code = code_q[DEPTH-1];

endmodule

// File: rtl/adc_sr_corr_merge.sv
module adc_sr_corr_merge
    import adc_subrange_pkg::*;
#(
    parameter int unsigned CRS_W = 3,
    parameter int unsigned FIN_W = 4,
    localparam int unsigned LOW_W = FIN_W - 1,
    localparam int unsigned OUT_W = CRS_W + LOW_W
) (
    input  logic [CRS_W-1:0] crs_code,
    input  logic [FIN_W-1:0] fin_code,
    output logic [OUT_W-1:0] word,
    output logic             ovr,
    output corr_act_e        act
);

    localparam logic [CRS_W-1:0] CRS_MAX = '1;

    logic fin_msb;
    assign fin_msb = fin_code[FIN_W-1];

    always_comb begin
        if (!fin_msb) begin
            act = ACT_PASS;
        end else if (crs_code == CRS_MAX) begin
            act = ACT_SAT;
        end else begin
            act = ACT_INCR;
        end
    end

    always_comb begin
        word = '0;
        ovr  = 1'b0;
        unique case (act)
            ACT_PASS: word = {crs_code, fin_code[LOW_W-1:0]};
            ACT_INCR: word = {crs_code + CRS_W'(1), fin_code[LOW_W-1:0]};
            ACT_SAT: begin
                word = '1;
                ovr  = 1'b1;
            end
            default: begin
                word = '0;
                ovr  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_subrange_corr.sv
module adc_subrange_corr
    import adc_subrange_pkg::*;
#(
    parameter int unsigned CRS_W     = CRS_W_DEF,
    parameter int unsigned FIN_W     = FIN_W_DEF,
    parameter int unsigned ALIGN_LAT = ALIGN_LAT_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   crs_vld,
    input  logic [CRS_W-1:0]       crs_code,
    input  logic                   fin_vld,
    input  logic [FIN_W-1:0]       fin_code,
    output logic                   out_vld,
    output logic [CRS_W+FIN_W-2:0] out_word,
    output logic                   out_ovr
);

    localparam int unsigned OUT_W = CRS_W + FIN_W - 1;

    logic             dly_vld;
    logic [CRS_W-1:0] dly_code;
    logic [OUT_W-1:0] mrg_word;
    logic             mrg_ovr;
    corr_act_e        mrg_act;

    adc_sr_crs_delay #(
        .W     (CRS_W),
        .DEPTH (ALIGN_LAT)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (crs_vld),
        .in_code  (crs_code),
        .out_vld  (dly_vld),
        .out_code (dly_code)
    );

    adc_sr_corr_merge #(
        .CRS_W (CRS_W),
        .FIN_W (FIN_W)
    ) u_mrg (
        .crs_code (dly_code),
        .fin_code (fin_code),
        .word     (mrg_word),
        .ovr      (mrg_ovr),
        .act      (mrg_act)
    );

    // Output register: loads on an accepted fine code, holds otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_word <= '0;
            out_ovr  <= 1'b0;
        end else begin
            out_vld <= fin_vld;
            if (fin_vld) begin
                out_word <= mrg_word;
                out_ovr  <= mrg_ovr;
            end
        end
    end

endmodule

// File: rtl/adc_subrange_corr_chk.sv
module adc_subrange_corr_chk #(
    parameter int unsigned CRS_W = 3,
    parameter int unsigned FIN_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fin_vld,
    input logic [FIN_W-1:0]       fin_code,
    input logic                   dly_vld,
    input logic                   out_vld,
    input logic [CRS_W+FIN_W-2:0] out_word,
    input logic                   out_ovr
);

    localparam int unsigned LOW_W = FIN_W - 1;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) fin_vld |=> out_vld);  // R2
    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !fin_vld |=> !out_vld);  // R2
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_vld && !fin_code[FIN_W-1]) |=> (out_word[LOW_W-1:0] == $past(fin_code[LOW_W-1:0])));  // R3
    AST_NO_OVR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_vld && !fin_code[FIN_W-1]) |=> !out_ovr);  // R4
    AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n) out_ovr |-> (&out_word));  // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_vld |=> ($stable(out_word) && $stable(out_ovr)));  // R8
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) fin_vld |-> dly_vld);  // R7

endmodule

bind adc_subrange_corr adc_subrange_corr_chk #(
    .CRS_W (CRS_W),
    .FIN_W (FIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_vld  (fin_vld),
    .fin_code (fin_code),
    .dly_vld  (dly_vld),
    .out_vld  (out_vld),
    .out_word (out_word),
    .out_ovr  (out_ovr)
);

// File: tb/sim_adc_subrange_corr.sv
`timescale 1ns/1ps
module sim_adc_subrange_corr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crs_vld = 1'b0;
    logic [2:0] crs_code = '0;
    logic       fin_vld = 1'b0;
    logic [3:0] fin_code = '0;
    logic       out_vld;
    logic [5:0] out_word;
    logic       out_ovr;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_subrange_corr u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .crs_vld  (crs_vld),
        .crs_code (crs_code),
        .fin_vld  (fin_vld),
        .fin_code (fin_code),
        .out_vld  (out_vld),
        .out_word (out_word),
        .out_ovr  (out_ovr)
    );

    function automatic logic [5:0] exp_word(input logic [2:0] c, input logic [3:0] f);
        if (f[3] && c == 3'd7) return 6'd63;
        return {c + {2'b00, f[3]}, f[2:0]};
    endfunction

    function automatic logic exp_ovr(input logic [2:0] c, input logic [3:0] f);
        return f[3] && (c == 3'd7);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One isolated sample: coarse, then fine one clock later (ALIGN_LAT = 1)
    task automatic one_pair(input string req, input logic [2:0] c, input logic [3:0] f);
        logic [5:0] held;
        @(negedge clk);
        crs_vld = 1'b1; crs_code = c;
        @(negedge clk);
        crs_vld = 1'b0; crs_code = 3'd0;
        fin_vld = 1'b1; fin_code = f;
        @(negedge clk);
        fin_vld = 1'b0; fin_code = 4'd0;
        check({req, " R2 vld"}, out_vld, 1);
        check({req, " word"}, out_word, exp_word(c, f));
        check({req, " R6 ovr"}, out_ovr, exp_ovr(c, f));
        held = out_word;
        @(negedge clk);
        check({req, " R2 vld drop"}, out_vld, 0);
        check({req, " R8 hold word"}, out_word, held);
        check({req, " R8 hold ovr"}, out_ovr, exp_ovr(c, f));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 vld in reset", out_vld, 0);
        check("R1 word in reset", out_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 vld idle", out_vld, 0);
        check("R1 word idle", out_word, 0);
        check("R1 ovr idle", out_ovr, 0);
    endtask

    task automatic t_pass;
        one_pair("R4 R3 pass c5 f6", 3'd5, 4'd6);
        one_pair("R4 R3 pass c0 f0", 3'd0, 4'd0);
        one_pair("R4 pass c7 f7", 3'd7, 4'd7);
    endtask

    task automatic t_incr;
        one_pair("R5 R3 incr c0 f9", 3'd0, 4'd9);
        one_pair("R5 incr c6 f15", 3'd6, 4'd15);
        one_pair("R5 incr c3 f8", 3'd3, 4'd8);
    endtask

    task automatic t_sat;
        one_pair("R6 sat c7 f8", 3'd7, 4'd8);
        one_pair("R6 sat c7 f13", 3'd7, 4'd13);
        one_pair("R6 clear after sat", 3'd2, 4'd1);
    endtask

    // Back-to-back stream, one new sample per clock
    task automatic t_stream;
        localparam int N = 16;
        logic [2:0] sc;
        logic [3:0] sf;
        for (int j = 0; j <= N + 1; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                sc = 3'((3 * (j - 2)) % 8);
                sf = 4'((5 * (j - 2) + 1) % 16);
                check("R7 stream vld", out_vld, 1);
                check("R7 stream word", out_word, exp_word(sc, sf));
                check("R7 stream ovr", out_ovr, exp_ovr(sc, sf));
            end
            crs_vld = (j < N);
            crs_code = (j < N) ? 3'((3 * j) % 8) : 3'd0;
            fin_vld = (j >= 1) && (j <= N);
            fin_code = fin_vld ? 4'((5 * (j - 1) + 1) % 16) : 4'd0;
        end
        @(negedge clk);
        check("R2 stream end", out_vld, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_pass();
        t_incr();
        t_sat();
        t_stream();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule